// File: doc/BRIEF.md
# Serial Configuration EEPROM Read Responder

This block stands in for a three-wire serial configuration EEPROM of 64 sixteen-bit words. A host controller reaches it by writing a control word whose chip-select, serial-clock and data-in bits are toggled in software. Each such write is presented as a one-cycle `strobe` together with the three bit values. The responder decodes a read command from these writes and answers on `dout`.

A transaction starts with the first 1 on data-in. Any zeros before it are discarded. Three opcode bits come next, then six address bits, both most significant bit first. While the address is being shifted in, `dout` is held high except on the final address bit, where it drops to 0. A host can count these bits to learn how wide the address is. Sixteen data bits follow, most significant first. After the 25th counted bit the responder clears its state, so a second read can follow at once without dropping select.

The storage is a byte array that is filled through a byte-wide preload port. Word `a` is formed from the byte at `2a` (low half) and the byte at `2a+1` (high half). Opcodes other than read are not served: `dout` reads 0 for the rest of that transaction and a sticky flag is raised.

Top module: `eeprom_rd_responder`

## Requirements
- R1: A strobe with `sel` high, following a strobe with `sel` low (or following reset), clears the bit count, the opcode, the address and the started state before that strobe's bit is considered.
- R2: A bit is taken only on a strobe with `sck` high, with `din` sampled there. Strobes with `sck` low and cycles without a strobe leave `dout` and the bit count unchanged.
- R3: Until a 1 has been taken, strobes carrying `din` = 0 do not count and do not change `dout`.
- R4: The first three counted bits form the opcode, MSB first. Opcode 3'b110 selects read.
- R5: During a read, the six counted bits after the opcode form the word address, MSB first. After each of the first five, `dout` is 1. After the sixth, it is 0.
- R6: During a read, the next sixteen counted bits each set `dout` to the addressed word, MSB first. The word is {byte[2a+1], byte[2a]}.
- R7: After 25 counted bits the state clears by itself, so a following read decodes correctly with `sel` held high.
- R8: After a non-read opcode, every counted bit of that transaction drives `dout` to 0 and sets `unsup`. `unsup` then stays 1 until reset.
- R9: A cycle with `pl_we` high writes `pl_data` into byte `pl_addr`, and later reads return it.
- R10: After reset, `dout` and `unsup` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_we | input | 1 | Preload byte write enable |
| pl_addr | input | 7 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| strobe | input | 1 | Host wrote the control bits this cycle |
| sel | input | 1 | Chip-select bit of the write |
| sck | input | 1 | Serial-clock bit of the write |
| din | input | 1 | Serial data-in bit of the write |
| dout | output | 1 | Serial data-out bit |
| unsup | output | 1 | Sticky flag for a non-read opcode |

## Verification
A bit count that is off by one shows up on the first read as a misplaced low address bit, and the data then comes out shifted one place. Both are visible one cycle after the offending strobe. A wrong opcode or address register gives wrong data bits or a spurious `unsup` within the same transaction. A restart that fails to clear is exposed by the second back-to-back read. A reference model checks `dout` and `unsup` on every clock, so any divergence is flagged in the cycle it appears.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_READ = 3'b110;
endpackage

// File: rtl/eeprom_rd_store.sv
module eeprom_rd_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int LANES = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int BYTE_AW = ADDR_W + LANE_W,
  localparam int NBYTES = 1 << BYTE_AW
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [BYTE_AW-1:0] wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_word
);
  logic [7:0] bytes_q [NBYTES];

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_addr] <= wr_data;
  end

  // lane g of the word sits at byte offset g, lowest lane first
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[8*g +: 8] = bytes_q[{rd_addr, LANE_W'(g)}];
  end
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int TOTAL = OPC_W + ADDR_W + WORD_W,
  localparam int CNT_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              sel,
  input  logic              sck,
  input  logic              din,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dout,
  output logic              unsup,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              started,
  output logic [OPC_W-1:0]  opcode,
  output logic              sel_prev
);
  localparam logic [CNT_W-1:0] C_OPC_END  = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(OPC_W + ADDR_W);
  localparam logic [CNT_W-1:0] C_ADDR_LST = CNT_W'(OPC_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OPC_W-1:0]  op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              st_q, st_d;
  logic              dout_q, dout_d;
  logic              un_q, un_d;
  logic              selq_q, selq_d;
  logic [CNT_W-1:0]  dix;
  logic [WORD_W-1:0] wsh;

  always_comb begin
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    st_d   = st_q;
    dout_d = dout_q;
    un_d   = un_q;
    selq_d = selq_q;
    dix    = '0;
    wsh    = '0;
    if (strobe) begin
      selq_d = sel;
      if (sel && !selq_q) begin
        cnt_d  = '0;
        op_d   = '0;
        addr_d = '0;
        st_d   = 1'b0;
      end
      if (sck && (din || st_d)) begin
        if (cnt_d < C_OPC_END) begin
          st_d = 1'b1;
          op_d = {op_d[OPC_W-2:0], din};
        end else if (op_d == OPC_READ) begin
          if (cnt_d < C_ADDR_END) begin
            dout_d = (cnt_d != C_ADDR_LST);
            addr_d = {addr_d[ADDR_W-2:0], din};
          end else begin
            dix    = cnt_d - C_ADDR_END;
            wsh    = word_i << dix;
            dout_d = wsh[WORD_W-1];
          end
        end else begin
          dout_d = 1'b0;
          un_d   = 1'b1;
        end
        if (cnt_d == C_LAST) begin
          cnt_d  = '0;
          op_d   = '0;
          addr_d = '0;
          st_d   = 1'b0;
        end else begin
          cnt_d = cnt_d + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      st_q   <= 1'b0;
      dout_q <= 1'b0;
      un_q   <= 1'b0;
      selq_q <= 1'b0;
    end else if (strobe) begin
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      st_q   <= st_d;
      dout_q <= dout_d;
      un_q   <= un_d;
      selq_q <= selq_d;
    end
  end

  assign addr_o   = addr_q;
  assign dout     = dout_q;
  assign unsup    = un_q;
  assign bit_cnt  = cnt_q;
  assign started  = st_q;
  assign opcode   = op_q;
  assign sel_prev = selq_q;
endmodule

// File: rtl/eeprom_rd_responder.sv
module eeprom_rd_responder
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int LANE_W = $clog2(WORD_W / 8),
  localparam int BYTE_AW = ADDR_W + LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pl_we,
  input  logic [BYTE_AW-1:0] pl_addr,
  input  logic [7:0]         pl_data,
  input  logic               strobe,
  input  logic               sel,
  input  logic               sck,
  input  logic               din,
  output logic               dout,
  output logic               unsup
);
  localparam int TOTAL = OPC_W + ADDR_W + WORD_W;
  localparam int CNT_W = $clog2(TOTAL);

  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              started;
  logic [OPC_W-1:0]  opcode;
  logic              sel_prev;

  eeprom_rd_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (pl_we),
    .wr_addr (pl_addr),
    .wr_data (pl_data),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  eeprom_rd_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .sel      (sel),
    .sck      (sck),
    .din      (din),
    .word_i   (rd_word),
    .addr_o   (rd_addr),
    .dout     (dout),
    .unsup    (unsup),
    .bit_cnt  (bit_cnt),
    .started  (started),
    .opcode   (opcode),
    .sel_prev (sel_prev)
  );
endmodule

// File: rtl/eeprom_rd_chk.sv
module eeprom_rd_chk
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int TOTAL = OPC_W + ADDR_W + WORD_W,
  localparam int CNT_W = $clog2(TOTAL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             sel,
  input logic             sck,
  input logic             din,
  input logic             dout,
  input logic             unsup,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             started,
  input logic [OPC_W-1:0] opcode,
  input logic             sel_prev
);
  localparam logic [CNT_W-1:0] K_OPC  = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] K_ALST = CNT_W'(OPC_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(TOTAL - 1);

  logic sel_rise, take;
  assign sel_rise = strobe && sel && !sel_prev;
  assign take = strobe && sck && !sel_rise;

  p_selrise_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise && !sck |=> (bit_cnt == '0) && !started);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(dout) && $stable(bit_cnt));
  p_lowclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !sck |=> $stable(dout));
  p_zero_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && sck && !din && !started |=> (bit_cnt == '0) && $stable(dout));
  p_addr_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && (opcode == OPC_READ) && (bit_cnt >= K_OPC) && (bit_cnt < K_ALST) |=> dout);
  p_addr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && (opcode == OPC_READ) && (bit_cnt == K_ALST) |=> !dout);
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= K_LAST);
  p_unsup_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |=> unsup);
  p_bad_op_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && started && (bit_cnt >= K_OPC) && (opcode != OPC_READ) |=> !dout && unsup);
endmodule

bind eeprom_rd_responder eeprom_rd_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .sel      (sel),
  .sck      (sck),
  .din      (din),
  .dout     (dout),
  .unsup    (unsup),
  .bit_cnt  (bit_cnt),
  .started  (started),
  .opcode   (opcode),
  .sel_prev (sel_prev)
);

// File: tb/test_eeprom_rd_responder.sv
`timescale 1ns/1ps
module test_eeprom_rd_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pl_we = 1'b0;
  logic [6:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic strobe = 1'b0, sel = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, unsup;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eeprom_rd_responder i_eeprom_rd_responder (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .strobe(strobe), .sel(sel), .sck(sck), .din(din), .dout(dout), .unsup(unsup)
  );

  // behavioural reference model
  logic [7:0] m_mem [128];
  int m_cnt, m_op, m_addr, m_word;
  bit m_st, m_dout, m_unsup, m_selq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_op = 0; m_addr = 0; m_st = 0;
      m_dout = 0; m_unsup = 0; m_selq = 0;
    end else begin
      if (pl_we) m_mem[pl_addr] = pl_data;
      if (strobe) begin
        if (sel && !m_selq) begin m_cnt = 0; m_op = 0; m_addr = 0; m_st = 0; end
        m_selq = sel;
        if (sck && (din || m_st)) begin
          if (m_cnt < 3) begin
            m_st = 1; m_op = (m_op * 2 + int'(din)) % 8;
          end else if (m_op == 6) begin
            if (m_cnt < 9) begin
              m_dout = (m_cnt != 8); m_addr = m_addr * 2 + int'(din);
            end else begin
              m_word = int'(m_mem[2*m_addr]) + 256 * int'(m_mem[2*m_addr+1]);
              m_dout = ((m_word >> (15 - (m_cnt - 9))) & 1) != 0;
            end
          end else begin
            m_dout = 0; m_unsup = 1;
          end
          m_cnt++;
          if (m_cnt == 25) begin m_cnt = 0; m_op = 0; m_addr = 0; m_st = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dout !== m_dout || unsup !== m_unsup) begin
        errors++;
        $display("FAIL R2 model compare: dout=%0b unsup=%0b expected dout=%0b unsup=%0b",
                 dout, unsup, m_dout, m_unsup);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [15:0] expw(input int a);
    return {pat(2*a+1), pat(2*a)};
  endfunction

  task automatic pulse(input logic s, input logic k, input logic d);
    @(negedge clk);
    sel = s; sck = k; din = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic send_bit(input logic d, output logic o);
    pulse(1'b1, 1'b0, d);
    pulse(1'b1, 1'b1, d);
    o = dout;
  endtask

  task automatic reselect();
    pulse(1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_read(input int a, input int zeros, output logic [5:0] apat, output logic [15:0] w);
    logic o;
    for (int i = 0; i < zeros; i++) send_bit(1'b0, o);
    send_bit(1'b1, o); send_bit(1'b1, o); send_bit(1'b0, o);
    for (int i = 5; i >= 0; i--) begin send_bit(a[i], o); apat[i] = o; end
    for (int i = 15; i >= 0; i--) begin send_bit(1'b0, o); w[i] = o; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] ap;
    logic [15:0] w;
    logic o, held;
    repeat (3) @(negedge clk);
    chk("R10 dout after reset", 32'(dout), 32'd0);
    chk("R10 unsup after reset", 32'(unsup), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      pl_we = 1'b1; pl_addr = 7'(i); pl_data = pat(i);
      @(negedge clk);
    end
    pl_we = 1'b0;
    reselect();

    do_read(21, 0, ap, w);
    chk("R5 address phase pattern", 32'(ap), 32'h3e);
    chk("R6 R4 R9 word 21", 32'(w), 32'(expw(21)));

    do_read(63, 0, ap, w);
    chk("R7 back-to-back word 63", 32'(w), 32'(expw(63)));
    do_read(0, 0, ap, w);
    chk("R7 back-to-back word 0", 32'(w), 32'(expw(0)));

    do_read(42, 5, ap, w);
    chk("R3 leading zeros pattern", 32'(ap), 32'h3e);
    chk("R3 leading zeros word 42", 32'(w), 32'(expw(42)));

    held = dout;
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b1);
    chk("R2 low-clock strobes keep dout", 32'(dout), 32'(held));
    do_read(9, 0, ap, w);
    chk("R2 read after low-clock strobes", 32'(w), 32'(expw(9)));

    send_bit(1'b1, o); send_bit(1'b1, o); send_bit(1'b0, o);
    send_bit(1'b1, o); send_bit(1'b0, o); send_bit(1'b1, o);
    reselect();
    do_read(7, 0, ap, w);
    chk("R1 reselect after partial read", 32'(w), 32'(expw(7)));

    chk("R8 flag clear before bad opcode", 32'(unsup), 32'd0);
    send_bit(1'b1, o); send_bit(1'b0, o); send_bit(1'b1, o);
    send_bit(1'b1, o);
    chk("R8 dout low after bad opcode", 32'(o), 32'd0);
    chk("R8 flag set", 32'(unsup), 32'd1);
    for (int i = 0; i < 21; i++) send_bit(1'b1, o);
    chk("R8 dout stays low", 32'(o), 32'd0);
    do_read(33, 0, ap, w);
    chk("R8 read after bad opcode", 32'(w), 32'(expw(33)));
    chk("R8 flag sticky", 32'(unsup), 32'd1);

    pl_we = 1'b1; pl_addr = 7'd100; pl_data = 8'hA5;
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 7'd101; pl_data = 8'h3C;
    @(negedge clk);
    pl_we = 1'b0;
    do_read(50, 0, ap, w);
    chk("R9 rewritten word 50", 32'(w), 32'h3ca5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule